// File: doc/BRIEF.md
# Two-Phase Multiplexed Address Capture Front End

This block is the device-side bus front end of a memory whose address arrives over a shared 16-bit bus in one or two phases. The phase is marked by a rising edge of an active-low address strobe. The level of the active-low output enable at that edge tells the two halves apart: low means the high address field, high means the low field. A chip-enable-low period delimits one bus cycle. The high field is kept across cycles, so a cycle that sends only the low field reuses the last high field it received.

When the low field is captured, the block forms the full address and raises a one-cycle sense-start pulse for the array. While reading, it drives the data bus and a WAIT handshake with the same enable. The array is modelled by a fixed data function of the address. In asynchronous mode WAIT always reports valid data. In synchronous mode WAIT reports valid data only once a programmed latency count has elapsed after the low-field capture. The block flags strobe sequences that break the one-or-two-phase ordering and ignores them.

All inputs are sampled on `clk`. A strobe rising edge is seen at the first clock edge where `adv_n` is high after being low at the edge before. Register updates caused by that edge become visible one clock later.

Top module: `mac_addr_front`

## Requirements
- R1: After reset, `full_addr` is zero (the high field register starts all zeros), `dq_oe`, `wait_oe`, `sense_start` and `proto_err` are 0, and `dq_out` is 0.
- R2: A strobe rising edge with `ce_n` low and `oe_n` low stores `ad_in[ADDR_W-17:0]` into `full_addr[ADDR_W-1:16]`. With `oe_n` high, it stores `ad_in` into `full_addr[15:0]`. The update is visible one clock after the detecting edge.
- R3: A cycle with only a low-field phase combines the new low field with the most recently stored high field, including one stored in an earlier cycle.
- R4: `sense_start` is high for exactly one clock, in the clock after the edge that captures a low field, in both one-phase and two-phase cycles. The high field is unchanged at that moment.
- R5: While `ce_n` is high, strobe edges are ignored. Raising `ce_n` restarts the phase count but keeps the stored high field. After `ce_n` has been high at a clock edge, `dq_oe` and `wait_oe` are 0.
- R6: A third strobe edge within one chip-enable-low cycle pulses `proto_err` for one clock. It changes no address bits and gives no `sense_start`.
- R7: A high-field strobe edge after a low-field capture in the same cycle pulses `proto_err` and leaves the high field unchanged.
- R8: `dq_oe` is 1 in the clock after each edge that sees `ce_n` low, `oe_n` low and a low field already captured in the current cycle; otherwise it is 0. `wait_oe` always equals `dq_oe`. Undriven `dq_out` and `wait_out` read 0.
- R9: Driven data equals `{lo[7:0], lo[15:8]} ^ hi`, where lo is `full_addr[15:0]` and hi is `full_addr[ADDR_W-1:16]` zero-extended to 16 bits.
- R10: With `cfg_async` = 1 (read-configuration bit 15), driven `wait_out` is always 1. With `cfg_async` = 0, driven `wait_out` is 1 only once at least `lat_cycles` clock edges have passed after the low-capture edge. At the edge just after the capture, the count of passed edges is 0, and a count of 0 means valid at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (mode entry) |
| ce_n | input | 1 | Chip enable, active low; delimits a bus cycle |
| adv_n | input | 1 | Address strobe, active low; capture on rising edge |
| oe_n | input | 1 | Output enable, active low; selects field at capture |
| ad_in | input | 16 | Shared address bus input |
| cfg_async | input | 1 | Read-config bit 15: 1 asynchronous, 0 synchronous |
| lat_cycles | input | LAT_W | Synchronous latency count in clocks |
| full_addr | output | ADDR_W | Assembled address |
| sense_start | output | 1 | One-clock pulse when array sensing starts |
| proto_err | output | 1 | One-clock pulse on an illegal strobe sequence |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| wait_out | output | 1 | WAIT level, 1 = data valid |
| wait_oe | output | 1 | WAIT drive enable |

## Verification
The hardest case to reach from the ports is the ordering error in which a high-field strobe follows a low-field capture within one chip-enable-low cycle. A naive driver always sends the fields in legal order, so this case never arises by chance. The bench steers into it with a directed cycle. It also makes the random loop skip the high phase in some cycles, so that reuse of an older high field is covered. Synchronous WAIT timing is covered by drawing random latencies, including 0. Each read is then held long enough that every latency boundary is sampled clock by clock.

// File: rtl/mac_addr_pkg.sv
package mac_addr_pkg;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } phase_e;

  // behavioural array content: byte-swapped low field mixed with high field
  function automatic logic [15:0] array_word(input logic [15:0] lo,
                                             input logic [15:0] hi_ext);
    return {lo[7:0], lo[15:8]} ^ hi_ext;
  endfunction

endpackage

// File: rtl/mac_phase_ctrl.sv
module mac_phase_ctrl
  import mac_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic adv_n,
  input  logic oe_n,
  output logic cap_hi,
  output logic cap_lo,
  output logic seq_err,
  output logic lo_seen
);

  logic   adv_q;
  phase_e phase_q, phase_d;
  logic   lo_q, lo_d;
  logic   rise;

  assign rise    = ~adv_q & adv_n & ~ce_n;
  assign lo_seen = lo_q;

  always_comb begin
    phase_d = phase_q;
    lo_d    = lo_q;
    cap_hi  = 1'b0;
    cap_lo  = 1'b0;
    seq_err = 1'b0;
    if (ce_n) begin
      phase_d = PH_NONE;
      lo_d    = 1'b0;
    end else if (rise) begin
      if (phase_q == PH_TWO) begin
        seq_err = 1'b1;
      end else if (!oe_n) begin
        if (lo_q) begin
          seq_err = 1'b1;
        end else begin
          cap_hi  = 1'b1;
          phase_d = (phase_q == PH_NONE) ? PH_ONE : PH_TWO;
        end
      end else begin
        cap_lo  = 1'b1;
        lo_d    = 1'b1;
        phase_d = (phase_q == PH_NONE) ? PH_ONE : PH_TWO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q   <= 1'b1;
      phase_q <= PH_NONE;
      lo_q    <= 1'b0;
    end else begin
      adv_q   <= adv_n;
      phase_q <= phase_d;
      lo_q    <= lo_d;
    end
  end

endmodule

// File: rtl/mac_addr_regs.sv
module mac_addr_regs #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_hi,
  input  logic            cap_lo,
  input  logic [15:0]     ad_in,
  output logic [HI_W-1:0] hi_q,
  output logic [15:0]     lo_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (cap_hi) begin
      hi_q <= ad_in[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_lo) begin
      lo_q <= ad_in;
    end
  end

endmodule

// File: rtl/mac_read_out.sv
module mac_read_out
  import mac_addr_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             cap_lo,
  input  logic             lo_seen,
  input  logic             cfg_async,
  input  logic [LAT_W-1:0] lat_cycles,
  input  logic [HI_W-1:0]  hi_q,
  input  logic [15:0]      lo_q,
  output logic [15:0]      dq_out,
  output logic             dq_oe,
  output logic             wait_out,
  output logic             wait_oe
);

  logic             drive_q, drive_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [15:0]      hi_ext;

  always_comb begin
    hi_ext             = '0;
    hi_ext[HI_W-1:0]   = hi_q;
  end

  always_comb begin
    drive_d = ~ce_n & lo_seen & ~oe_n;
    lat_d   = lat_q;
    if (cap_lo) begin
      lat_d = lat_cycles;
    end else if (lat_q != '0) begin
      lat_d = lat_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      lat_q   <= '0;
    end else begin
      drive_q <= drive_d;
      lat_q   <= lat_d;
    end
  end

  assign dq_oe    = drive_q;
  assign wait_oe  = drive_q;
  assign dq_out   = drive_q ? array_word(lo_q, hi_ext) : 16'h0000;
  assign wait_out = drive_q & (cfg_async | (lat_q == '0));

endmodule

// File: rtl/mac_addr_front.sv
module mac_addr_front #(
  parameter int ADDR_W = 24,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [15:0]       ad_in,
  input  logic              cfg_async,
  input  logic [LAT_W-1:0]  lat_cycles,
  output logic [ADDR_W-1:0] full_addr,
  output logic              sense_start,
  output logic              proto_err,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              wait_out,
  output logic              wait_oe
);

  localparam int HI_W = ADDR_W - 16;

  logic            cap_hi, cap_lo, seq_err, lo_seen;
  logic [HI_W-1:0] hi_q;
  logic [15:0]     lo_q;
  logic            sense_q, err_q;

  mac_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .adv_n   (adv_n),
    .oe_n    (oe_n),
    .cap_hi  (cap_hi),
    .cap_lo  (cap_lo),
    .seq_err (seq_err),
    .lo_seen (lo_seen)
  );

  mac_addr_regs #(.HI_W(HI_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_hi (cap_hi),
    .cap_lo (cap_lo),
    .ad_in  (ad_in),
    .hi_q   (hi_q),
    .lo_q   (lo_q)
  );

  mac_read_out #(.HI_W(HI_W), .LAT_W(LAT_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .cap_lo     (cap_lo),
    .lo_seen    (lo_seen),
    .cfg_async  (cfg_async),
    .lat_cycles (lat_cycles),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .wait_out   (wait_out),
    .wait_oe    (wait_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sense_q <= cap_lo;
      err_q   <= seq_err;
    end
  end

  assign full_addr   = {hi_q, lo_q};
  assign sense_start = sense_q;
  assign proto_err   = err_q;

endmodule

// File: rtl/mac_front_chk.sv
module mac_front_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic [ADDR_W-1:0] full_addr,
  input logic              sense_start,
  input logic              proto_err,
  input logic              dq_oe,
  input logic              wait_oe
);

  p_hi_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |-> full_addr[ADDR_W-1:16] == $past(full_addr[ADDR_W-1:16]));

  p_err_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> full_addr == $past(full_addr));

  p_err_no_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !sense_start);

  p_ce_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dq_oe && !wait_oe));

endmodule

bind mac_addr_front mac_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (ce_n),
  .full_addr   (full_addr),
  .sense_start (sense_start),
  .proto_err   (proto_err),
  .dq_oe       (dq_oe),
  .wait_oe     (wait_oe)
);

// File: tb/mac_addr_front_tb.sv
module mac_addr_front_tb;

  localparam int ADDR_W = 24;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, adv_n, oe_n, cfg_async;
  logic [15:0]       ad_in;
  logic [LAT_W-1:0]  lat_cycles;
  logic [ADDR_W-1:0] full_addr;
  logic              sense_start, proto_err, dq_oe, wait_out, wait_oe;
  logic [15:0]       dq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0]  m_hi;
  logic [15:0] m_lo;

  always #2 clk = ~clk;

  mac_addr_front #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .ad_in(ad_in), .cfg_async(cfg_async), .lat_cycles(lat_cycles),
    .full_addr(full_addr), .sense_start(sense_start), .proto_err(proto_err),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_out(wait_out), .wait_oe(wait_oe)
  );

  function automatic logic [15:0] exp_data(input logic [7:0] hi, input logic [15:0] lo);
    return {lo[7:0], lo[15:8]} ^ {8'h00, hi};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe pulse; returns at the negedge where its effect is visible
  task automatic strobe(input bit hi_phase, input logic [15:0] val);
    @(negedge clk);
    oe_n  = hi_phase ? 1'b0 : 1'b1;
    ad_in = val;
    adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
    @(negedge clk);
  endtask

  // called right after a low capture; reads and checks data and WAIT
  task automatic do_read(input string req);
    chk({req, " R4 sense"}, {31'd0, sense_start}, 32'd1);
    oe_n = 1'b0;
    for (int k = 1; k <= int'(lat_cycles) + 2; k++) begin
      @(negedge clk);
      if (k == 1) chk("R4 pulse ends", {31'd0, sense_start}, 32'd0);
      chk({req, " R8 dq_oe"}, {31'd0, dq_oe}, 32'd1);
      chk({req, " R8 wait_oe"}, {31'd0, wait_oe}, 32'd1);
      chk({req, " R9 data"}, {16'd0, dq_out}, {16'd0, exp_data(m_hi, m_lo)});
      chk({req, " R10 wait"}, {31'd0, wait_out},
          {31'd0, (cfg_async || k >= int'(lat_cycles))});
    end
    oe_n = 1'b1;
    @(negedge clk);
    chk("R8 release", {31'd0, dq_oe}, 32'd0);
    chk("R8 undriven", {15'd0, wait_out, dq_out}, 32'd0);
  endtask

  task automatic end_cycle();
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    chk("R5 quiet", {30'd0, dq_oe, wait_oe}, 32'd0);
    ce_n = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1;
    ad_in = '0; cfg_async = 1'b1; lat_cycles = '0;
    m_hi = '0; m_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr", {8'd0, full_addr}, 32'd0);
    chk("R1 enables", {28'd0, dq_oe, wait_oe, sense_start, proto_err}, 32'd0);
    chk("R1 dq", {16'd0, dq_out}, 32'd0);

    // two-phase, async
    ce_n = 1'b0;
    strobe(1'b1, 16'h00AB); m_hi = 8'hAB;
    chk("R2 hi", {8'd0, full_addr}, {8'd0, m_hi, m_lo});
    chk("R4 no sense on hi", {31'd0, sense_start}, 32'd0);
    strobe(1'b0, 16'h1234); m_lo = 16'h1234;
    chk("R2 lo", {8'd0, full_addr}, 32'h00AB1234);
    do_read("two-phase async");
    end_cycle();

    // single-phase reuses hi, sync latency 3
    cfg_async = 1'b0; lat_cycles = 4'd3;
    strobe(1'b0, 16'h5555); m_lo = 16'h5555;
    chk("R3 single", {8'd0, full_addr}, 32'h00AB5555);
    do_read("single sync");
    // ce high while oe low stops drive
    oe_n = 1'b0;
    @(negedge clk);
    chk("R8 oe low drives", {31'd0, dq_oe}, 32'd1);
    ce_n = 1'b1;
    @(negedge clk);
    chk("R5 ce high stops", {31'd0, dq_oe}, 32'd0);
    oe_n = 1'b1; ce_n = 1'b0;

    // third strobe -> error
    strobe(1'b1, 16'h0011); m_hi = 8'h11;
    strobe(1'b0, 16'h2222); m_lo = 16'h2222;
    strobe(1'b1, 16'h0033);
    chk("R6 err", {31'd0, proto_err}, 32'd1);
    chk("R6 no sense", {31'd0, sense_start}, 32'd0);
    chk("R6 addr kept", {8'd0, full_addr}, 32'h00112222);
    @(negedge clk);
    chk("R6 err one clock", {31'd0, proto_err}, 32'd0);
    end_cycle();

    // hi after lo -> error
    strobe(1'b0, 16'h4444); m_lo = 16'h4444;
    strobe(1'b1, 16'h0077);
    chk("R7 err", {31'd0, proto_err}, 32'd1);
    chk("R7 hi kept", {8'd0, full_addr}, 32'h00114444);
    end_cycle();

    // strobe ignored while ce high, hi kept across cycles
    ce_n = 1'b1;
    strobe(1'b1, 16'h0099);
    chk("R5 ignored", {8'd0, full_addr}, 32'h00114444);
    chk("R5 no sense", {30'd0, sense_start, proto_err}, 32'd0);
    ce_n = 1'b0;
    lat_cycles = 4'd0;
    strobe(1'b0, 16'hBEEF); m_lo = 16'hBEEF;
    chk("R3 kept hi", {8'd0, full_addr}, 32'h0011BEEF);
    do_read("sync lat0");
    end_cycle();

    // random cycles
    for (int i = 0; i < 150; i++) begin
      cfg_async  = 1'($urandom_range(0, 1));
      lat_cycles = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 2) != 0) begin
        logic [15:0] v;
        v = 16'($urandom);
        strobe(1'b1, v); m_hi = v[7:0];
        chk("R2 rand hi", {24'd0, full_addr[23:16]}, {24'd0, m_hi});
      end
      begin
        logic [15:0] w;
        w = 16'($urandom);
        strobe(1'b0, w); m_lo = w;
      end
      chk("R3 rand addr", {8'd0, full_addr}, {8'd0, m_hi, m_lo});
      do_read("random");
      end_cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule